// File: doc/BRIEF.md
# Attention Request Gate for a Shared Sensor Bus

This block sits in a slave device on a shared single-wire sensor bus and decides when that slave may ask the bit-signalling layer to drive an attention pulse. Two kinds of event can lead to a pulse. A function event sets a status flag, and it counts only if attention is enabled. A bus error always counts. Either kind is held pending until the bus goes inactive. A pulse is never requested while the bus is busy.

Function-event attentions are limited to one per scan. Once any attention has appeared on the bus, either this device's own or one observed from another device, function-event attentions are blocked until the device status register is read or a bus reset occurs. The blocking covers other devices because a request does not identify its sender. A blocked function event is dropped for attention purposes at its first inactive-bus cycle, and its status flag stays set for the master's scan. Bus-error attentions ignore this blocking and are cancelled only by a bus reset. If both kinds are pending at once, a single pulse serves both.

The block registers every event before deciding. The pulse request is itself a register, so the request appears one cycle after the inactive-bus cycle in which the decision is made.

Top module: `attn_gate`

## Requirements
- R1: While `rst` is high, `attn_req_o` is low. Events that were pending before or during reset never produce a pulse after reset is released.
- R2: An enabled function event is sampled in cycle t, with no blocking and the bus inactive in cycle t+1. Then `attn_req_o` is high for one cycle, visible after the clock edge that ends cycle t+1. This also holds when the bus is already inactive in cycle t.
- R3: A function event sampled while `attn_en_i` is low produces no pulse.
- R4: `attn_req_o` is never high in the cycle after a cycle with `bus_idle_i` low. A pending event is kept through any number of busy cycles and is acted on at the first inactive cycle.
- R5: After this device issues a pulse, function events produce no pulse until a status-register read (`stat_rd_i` high). After the read, function events produce pulses again.
- R6: An attention observed on the bus (`attn_seen_i` high) blocks function-event pulses in the same way as R5. This includes an observation in the same cycle as the inactive-bus decision.
- R7: A pending function event that is blocked at its first inactive-bus cycle is dropped. It produces no pulse later, even after a status-register read.
- R8: A pending bus error produces a pulse at the first inactive-bus cycle, whether or not function attentions are blocked.
- R9: A bus reset (`bus_rst_i` high) cancels any pending bus error and any pending function event, and clears the blocking. A bus reset wins over an event that is sampled in the same cycle.
- R10: When a function event and a bus error are pending together, one single-cycle pulse is issued and both are cleared. No second pulse follows.
- R11: A status-register read and a bus reset in the same cycle clear the blocking. An attention observed in the same cycle as a read leaves the blocking set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_evt_i | input | 1 | One-cycle pulse: a function event set the status flag |
| attn_en_i | input | 1 | Attention enable for function events |
| bus_err_i | input | 1 | One-cycle pulse: a bus error was detected |
| bus_idle_i | input | 1 | High while the bus is inactive |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset seen |
| stat_rd_i | input | 1 | One-cycle pulse: device status register was read |
| attn_seen_i | input | 1 | One-cycle pulse: an attention from any device was observed |
| attn_req_o | output | 1 | Registered one-cycle request to drive an attention pulse |

## Verification
The main function is driven with five patterns:
- A lone function event on a free bus, which shows the basic latency.
- Events held through busy stretches, which separates holding from dropping.
- Function events after the device's own pulse, and after an observed pulse from another device, which shows that both sources set the blocking.
- Bus errors while blocked, which shows that errors bypass the blocking.
- A function event and a bus error pending together, which shows that one pulse covers both.

Corner cases follow. These are same-cycle collisions between read, reset, observation and events, which fix the priority of set against clear. They also include a reset taken with events pending, which shows that nothing leaks across reset.

// File: rtl/attn_pkg.sv
package attn_pkg;

  // Bus-side conditions seen by the suppression tracker.
  typedef struct packed {
    logic idle;
    logic reset;
    logic sreg_rd;
    logic seen;
  } bus_view_t;

  // Outcome of the inactive-bus decision for one cycle.
  typedef enum logic [1:0] {
    DEC_WAIT  = 2'd0,
    DEC_ISSUE = 2'd1,
    DEC_DROP  = 2'd2
  } attn_dec_e;

endpackage

// File: rtl/attn_func_track.sv
module attn_func_track
  import attn_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      evt_i,
  input  logic      en_i,
  input  bus_view_t view_i,
  input  logic      fire_i,
  output logic      pend_o,
  output logic      block_o
);

  logic pend_q;
  logic supp_q;

  // Pending function event: the reset wins, then a new event, then the
  // first inactive cycle consumes it (issued or dropped).
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (view_i.reset) begin
      pend_q <= 1'b0;
    end else if (evt_i && en_i) begin
      pend_q <= 1'b1;
    end else if (view_i.idle) begin
      pend_q <= 1'b0;
    end
  end

  // Suppression: setting (an attention on the bus) wins over clearing.
  always_ff @(posedge clk) begin
    if (rst) begin
      supp_q <= 1'b0;
    end else if (view_i.seen || fire_i) begin
      supp_q <= 1'b1;
    end else if (view_i.sreg_rd || view_i.reset) begin
      supp_q <= 1'b0;
    end
  end

  assign pend_o  = pend_q;
  assign block_o = supp_q | view_i.seen;

  assert_disabled_evt_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_i && !en_i && !pend_q) |=> !pend_q);

  assert_supp_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (supp_q && !view_i.sreg_rd && !view_i.reset) |=> supp_q);

  assert_seen_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    view_i.seen |=> supp_q);

  assert_busrst_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (view_i.reset && !view_i.seen) |=> (!supp_q && !pend_q));

endmodule

// File: rtl/attn_err_track.sv
module attn_err_track (
  input  logic clk,
  input  logic rst,
  input  logic err_i,
  input  logic bus_reset_i,
  input  logic fire_i,
  output logic pend_o
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (bus_reset_i) begin
      pend_q <= 1'b0;
    end else if (err_i) begin
      pend_q <= 1'b1;
    end else if (fire_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  assert_err_cancel_R9: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> !pend_q);

endmodule

// File: rtl/attn_issue.sv
module attn_issue
  import attn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic func_pend_i,
  input  logic func_block_i,
  input  logic err_pend_i,
  input  logic idle_i,
  input  logic bus_reset_i,
  output logic fire_o,
  output logic req_o
);

  attn_dec_e dec;
  logic      req_q;

  always_comb begin
    dec = DEC_WAIT;
    if (idle_i && !bus_reset_i) begin
      if (err_pend_i || (func_pend_i && !func_block_i)) begin
        dec = DEC_ISSUE;
      end else if (func_pend_i) begin
        dec = DEC_DROP;
      end
    end
  end

  assign fire_o = (dec == DEC_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= fire_o;
    end
  end

  assign req_o = req_q;

  assert_unblocked_issue_R2: assert property (@(posedge clk) disable iff (rst)
    (func_pend_i && !func_block_i && idle_i && !bus_reset_i) |=> req_q);

  assert_busy_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !idle_i |=> !req_q);

  assert_blocked_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (func_pend_i && func_block_i && !err_pend_i) |=> !req_q);

  assert_err_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (err_pend_i && idle_i && !bus_reset_i) |=> req_q);

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> !req_q);

endmodule

// File: rtl/attn_gate.sv
module attn_gate
  import attn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic func_evt_i,
  input  logic attn_en_i,
  input  logic bus_err_i,
  input  logic bus_idle_i,
  input  logic bus_rst_i,
  input  logic stat_rd_i,
  input  logic attn_seen_i,
  output logic attn_req_o
);

  bus_view_t view;
  logic      fire;
  logic      func_pend;
  logic      func_block;
  logic      err_pend;

  assign view.idle    = bus_idle_i;
  assign view.reset   = bus_rst_i;
  assign view.sreg_rd = stat_rd_i;
  assign view.seen    = attn_seen_i;

  attn_func_track u_func (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (func_evt_i),
    .en_i    (attn_en_i),
    .view_i  (view),
    .fire_i  (fire),
    .pend_o  (func_pend),
    .block_o (func_block)
  );

  attn_err_track u_err (
    .clk         (clk),
    .rst         (rst),
    .err_i       (bus_err_i),
    .bus_reset_i (bus_rst_i),
    .fire_i      (fire),
    .pend_o      (err_pend)
  );

  attn_issue u_issue (
    .clk          (clk),
    .rst          (rst),
    .func_pend_i  (func_pend),
    .func_block_i (func_block),
    .err_pend_i   (err_pend),
    .idle_i       (bus_idle_i),
    .bus_reset_i  (bus_rst_i),
    .fire_o       (fire),
    .req_o        (attn_req_o)
  );

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !attn_req_o);

  assert_joint_single_R10: assert property (@(posedge clk) disable iff (rst)
    (attn_req_o && !$past(func_evt_i) && !$past(bus_err_i)) |=> !attn_req_o);

endmodule

// File: tb/tb_attn_gate.sv
`timescale 1ns/1ps
module tb_attn_gate;

  logic clk = 1'b0;
  logic rst;
  logic func_evt, attn_en, bus_err, bus_idle, bus_rst, stat_rd, attn_seen;
  logic attn_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  attn_gate dut (
    .clk         (clk),
    .rst         (rst),
    .func_evt_i  (func_evt),
    .attn_en_i   (attn_en),
    .bus_err_i   (bus_err),
    .bus_idle_i  (bus_idle),
    .bus_rst_i   (bus_rst),
    .stat_rd_i   (stat_rd),
    .attn_seen_i (attn_seen),
    .attn_req_o  (attn_req)
  );

  // Row: {req[3:0], func, en, err, idle, busrst, read, seen, expected}
  localparam logic [11:0] VEC [22] = '{
    {4'd4,  8'b11000000},
    {4'd4,  8'b00000000},
    {4'd2,  8'b00010001},
    {4'd5,  8'b11010000},
    {4'd5,  8'b00010000},
    {4'd5,  8'b00010100},
    {4'd7,  8'b00010000},
    {4'd5,  8'b11000000},
    {4'd5,  8'b00010001},
    {4'd8,  8'b00100000},
    {4'd8,  8'b00010001},
    {4'd6,  8'b00000100},
    {4'd6,  8'b00000010},
    {4'd6,  8'b11000000},
    {4'd6,  8'b00010000},
    {4'd10, 8'b00000100},
    {4'd10, 8'b11100000},
    {4'd10, 8'b00010001},
    {4'd10, 8'b00010000},
    {4'd5,  8'b11000000},
    {4'd5,  8'b00010000},
    {4'd7,  8'b00010000}
  };

  function automatic string req_name(input int n);
    case (n)
      1:  return "R1";
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input logic exp, input string tag);
    checks++;
    if (attn_req !== exp) begin
      fails++;
      $display("FAIL %s: attn_req_o=%b expected %b at %0t", tag, attn_req, exp, $time);
    end
  endtask

  task automatic step(input logic f, e, er, id, br, rd, sn, ex, input string tag);
    @(negedge clk);
    func_evt = f; attn_en = e; bus_err = er; bus_idle = id;
    bus_rst = br; stat_rd = rd; attn_seen = sn;
    @(posedge clk);
    #1;
    check(ex, tag);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    func_evt = 0; attn_en = 0; bus_err = 0; bus_idle = 1;
    bus_rst = 0; stat_rd = 0; attn_seen = 0;
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R1 reset");
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 22; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2],
           VEC[i][1], VEC[i][0], req_name(int'(VEC[i][11:8])));
    end

    // R3: disabled event ignored; then R2 with bus already idle
    step(0,0,0,0,0,1,0,0, "R3 read");
    step(1,0,0,0,0,0,0,0, "R3");
    step(0,0,0,1,0,0,0,0, "R3");
    step(0,0,0,1,0,0,0,0, "R3");
    step(1,1,0,1,0,0,0,0, "R2");
    step(0,0,0,1,0,0,0,1, "R2");
    step(0,0,0,1,0,0,0,0, "R2 one cycle");

    // R9: bus reset clears suppression
    step(0,0,0,0,1,0,0,0, "R9");
    step(1,1,0,0,0,0,0,0, "R9");
    step(0,0,0,1,0,0,0,1, "R9 unblocked");
    // R9: bus reset cancels pending error
    step(0,0,1,0,0,0,0,0, "R9");
    step(0,0,0,0,1,0,0,0, "R9");
    step(0,0,0,1,0,0,0,0, "R9 err cancelled");
    // R9: reset wins over same-cycle error and function event
    step(0,0,1,0,1,0,0,0, "R9");
    step(0,0,0,1,0,0,0,0, "R9 err same cycle");
    step(1,1,0,0,1,0,0,0, "R9");
    step(0,0,0,1,0,0,0,0, "R9 func same cycle");

    // R11: read and bus reset together clear suppression
    step(0,0,0,0,0,0,1,0, "R11");
    step(0,0,0,0,1,1,0,0, "R11");
    step(1,1,0,0,0,0,0,0, "R11");
    step(0,0,0,1,0,0,0,1, "R11 cleared");
    // R11: seen with read keeps suppression
    step(0,0,0,0,0,1,1,0, "R11");
    step(1,1,0,0,0,0,0,0, "R11");
    step(0,0,0,1,0,0,0,0, "R11 still blocked");

    // R6: observation in the decision cycle blocks
    step(0,0,0,0,0,1,0,0, "R6");
    step(1,1,0,0,0,0,0,0, "R6");
    step(0,0,0,1,0,0,1,0, "R6 same cycle");
    step(0,0,0,1,0,0,0,0, "R6 dropped");

    // R1: reset with events pending
    step(0,0,0,0,0,1,0,0, "R1");
    step(1,1,1,0,0,0,0,0, "R1");
    @(negedge clk);
    rst = 1'b1;
    func_evt = 0; attn_en = 0; bus_err = 0; bus_idle = 1;
    @(posedge clk);
    #1;
    check(1'b0, "R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    step(0,0,0,1,0,0,0,0, "R1 no leak");
    step(0,0,0,1,0,0,0,0, "R1 no leak");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule